// File: doc/BRIEF.md
# XGMII Test Frame Source

This block drives a 64-bit XGMII-style transmit path with simple test frames for link loopback checks. Each cycle it presents eight byte lanes together with an 8-bit control mask. A set mask bit marks the byte in that lane as a control character. When the block is not asked to send, it fills every lane with idle characters.

While `enable` is held high, the block sends frames back to back. Each frame is a start-and-preamble word, then a fixed number of payload words, then a terminate word, and then a fixed run of idle words as the inter-packet gap. The payload bytes are the successive values of an 8-bit counter that restarts at zero in every frame. A receiver can therefore rebuild the expected data without any side channel. The payload length and the gap length are parameters fixed at elaboration.

A frame that has started always runs to completion, including its gap, even if `enable` falls partway through. The link never carries a truncated frame.

Top module: `xgmii_frame_gen`

## Requirements
- R1: During reset, and after reset until a frame starts, every lane carries 0x07 and the control mask is 0xFF. Lane k occupies data bits [8k+7:8k], and control bit k belongs to lane k.
- R2: While no frame is in progress and `enable` is low, the output stays at the idle word (0x07 in all lanes, control 0xFF).
- R3: If `enable` is high at a rising clock edge while the block is idle, the start word appears on the outputs right after that edge.
- R4: The start word has 0xFB in lane 0, 0x55 in lanes 1 to 6 and 0xD5 in lane 7, with control mask 0x01.
- R5: The start word is followed by exactly PAYLOAD_WORDS payload words with control mask 0x00. Lane k of payload word w carries (8w + k) mod 256.
- R6: The payload counter wraps from 0xFF to 0x00 inside a frame and carries on counting from there.
- R7: The payload counter restarts at 0x00 in every frame, so the first payload byte of each frame is 0x00.
- R8: The last payload word is followed by the terminate word: 0xFD in lane 0, 0x07 in lanes 1 to 7, control mask 0xFF.
- R9: The terminate word is followed by exactly GAP_WORDS idle words. If `enable` is high at the edge after the last gap word, the next start word follows with no extra idle.
- R10: If `enable` falls during a frame, the frame still completes through its terminate word and gap, and then the output stays idle.
- R11: If `enable` rises during a gap, no start word appears before the gap is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Request to send frames; sampled at frame boundaries |
| txd | output | 64 | Eight byte lanes of transmit data, lane 0 in bits [7:0] |
| txc | output | 8 | Per-lane control mask, bit k set when lane k holds a control character |

## Verification
The bench uses a payload long enough (34 words) that the byte counter wraps inside one frame. A design that carries the wrap wrongly, or that never resets the counter between frames, breaks the byte sequence seen by a predicting receiver.

It holds `enable` high across several frames to catch a gap that is one word too long or too short, and a restart that inserts a stray idle. It drops `enable` in mid-payload; a design that aborted there would emit a frame with no terminate word. It also raises `enable` inside a gap; a design that started early would shorten the gap.

// File: rtl/xfg_pkg.sv
package xfg_pkg;

  localparam int unsigned LANES  = 8;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;

  localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
  localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
  localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [BYTE_W-1:0] CH_PRE   = 8'h55;
  localparam logic [BYTE_W-1:0] CH_SFD   = 8'hD5;

  localparam logic [LANES-1:0] MASK_ALL  = '1;
  localparam logic [LANES-1:0] MASK_NONE = '0;
  localparam logic [LANES-1:0] MASK_LN0  = LANES'(1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_TERM,
    ST_GAP
  } xfg_state_e;

  function automatic logic [WORD_W-1:0] fill_word(input logic [BYTE_W-1:0] b);
    fill_word = {LANES{b}};
  endfunction

endpackage

// File: rtl/xfg_rst_sync.sv
module xfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/xfg_seq.sv
module xfg_seq
  import xfg_pkg::*;
#(
  parameter int unsigned PAYLOAD_WORDS = 8,
  parameter int unsigned GAP_WORDS     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  output xfg_state_e state_q,
  output xfg_state_e state_nxt,
  output logic       restart,
  output logic       advance
);

  localparam int unsigned MAX_RUN = (PAYLOAD_WORDS > GAP_WORDS) ? PAYLOAD_WORDS : GAP_WORDS;
  localparam int unsigned CNT_W   = (MAX_RUN > 1) ? $clog2(MAX_RUN) : 1;
  localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAYLOAD_WORDS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_WORDS - 1);

  generate
    if (PAYLOAD_WORDS < 1 || GAP_WORDS < 1) begin : g_bad_len
      $error("xfg_seq: PAYLOAD_WORDS and GAP_WORDS must both be at least 1");
    end
  endgenerate

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             run_state;

  // Next-state logic
  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: if (enable) state_nxt = ST_HDR;
      ST_HDR:  state_nxt = ST_PAY;
      ST_PAY:  if (cnt_q == PAY_LAST) state_nxt = ST_TERM;
      ST_TERM: state_nxt = ST_GAP;
      ST_GAP:  if (cnt_q == GAP_LAST) state_nxt = enable ? ST_HDR : ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  assign run_state = (state_q == ST_PAY) || (state_q == ST_GAP);

  always_comb begin
    if (run_state && (state_nxt == state_q)) cnt_d = cnt_q + CNT_W'(1);
    else                                     cnt_d = '0;
  end

  assign cnt_en  = (cnt_d != cnt_q);
  assign restart = (state_nxt == ST_HDR);
  assign advance = (state_nxt == ST_PAY);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !enable) |=> (state_q == ST_IDLE));

  // R9
  term_to_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TERM) |=> (state_q == ST_GAP));

  // R9
  gap_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (cnt_q <= GAP_LAST));

  // R5
  pay_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAY) |-> (cnt_q <= PAY_LAST));

  // R11
  gap_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && cnt_q != GAP_LAST) |=> (state_q == ST_GAP));

  // R10
  pay_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAY && !enable) |=> (state_q == ST_PAY || state_q == ST_TERM));

endmodule

// File: rtl/xfg_payload.sv
module xfg_payload
  import xfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic [WORD_W-1:0] word_o
);

  localparam logic [BYTE_W-1:0] STEP = BYTE_W'(LANES);

  logic [BYTE_W-1:0] base_q;
  logic [BYTE_W-1:0] base_d;
  logic              base_en;

  always_comb begin
    base_d = base_q;
    if (restart)      base_d = '0;
    else if (advance) base_d = base_q + STEP;
  end

  assign base_en = restart || advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  // Lane k of the current payload word is the base count plus k, mod 256
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign word_o[k*BYTE_W +: BYTE_W] = base_q + BYTE_W'(k);
    end
  endgenerate

endmodule

// File: rtl/xfg_word_mux.sv
module xfg_word_mux
  import xfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  xfg_state_e        state_nxt,
  input  logic [WORD_W-1:0] pay_word,
  output logic [WORD_W-1:0] data_q,
  output logic [LANES-1:0]  ctrl_q
);

  logic [WORD_W-1:0] data_d;
  logic [LANES-1:0]  ctrl_d;

  always_comb begin
    unique case (state_nxt)
      ST_HDR: begin
        data_d = {CH_SFD, {(LANES-2){CH_PRE}}, CH_START};
        ctrl_d = MASK_LN0;
      end
      ST_PAY: begin
        data_d = pay_word;
        ctrl_d = MASK_NONE;
      end
      ST_TERM: begin
        data_d = {{(LANES-1){CH_IDLE}}, CH_TERM};
        ctrl_d = MASK_ALL;
      end
      default: begin
        data_d = fill_word(CH_IDLE);
        ctrl_d = MASK_ALL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= fill_word(CH_IDLE);
      ctrl_q <= MASK_ALL;
    end else begin
      data_q <= data_d;
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/xgmii_frame_gen.sv
module xgmii_frame_gen
  import xfg_pkg::*;
#(
  parameter int unsigned PAYLOAD_WORDS = 8,
  parameter int unsigned GAP_WORDS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic [WORD_W-1:0] txd,
  output logic [LANES-1:0]  txc
);

  logic              rst_n_s;
  xfg_state_e        state_q;
  xfg_state_e        state_nxt;
  logic              restart;
  logic              advance;
  logic [WORD_W-1:0] pay_word;

  xfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  xfg_seq #(
    .PAYLOAD_WORDS (PAYLOAD_WORDS),
    .GAP_WORDS     (GAP_WORDS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .enable    (enable),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .restart   (restart),
    .advance   (advance)
  );

  xfg_payload u_pay (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .restart (restart),
    .advance (advance),
    .word_o  (pay_word)
  );

  xfg_word_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .state_nxt (state_nxt),
    .pay_word  (pay_word),
    .data_q    (txd),
    .ctrl_q    (txc)
  );

  // R5
  generate
    for (genvar k = 1; k < LANES; k++) begin : g_lane_chk
      lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        (txc == MASK_NONE) |->
          (txd[k*BYTE_W +: BYTE_W] == txd[(k-1)*BYTE_W +: BYTE_W] + 8'd1));
    end
  endgenerate

  // R6
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(txc) == MASK_NONE && txc == MASK_NONE) |->
      (txd[BYTE_W-1:0] == $past(txd[WORD_W-1 -: BYTE_W]) + 8'd1));

  // R4
  header_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (txc == MASK_LN0) |->
      (txd[BYTE_W-1:0] == CH_START && txd[WORD_W-1 -: BYTE_W] == CH_SFD));

  // R7
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(txc) == MASK_LN0) |-> (txc == MASK_NONE && txd[BYTE_W-1:0] == 8'h00));

  // R8
  term_after_pay_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (txc == MASK_ALL && txd[BYTE_W-1:0] == CH_TERM) |-> ($past(txc) == MASK_NONE));

endmodule

// File: tb/xgmii_frame_gen_tb.sv
module xgmii_frame_gen_tb_top;

  localparam int PW = 34;
  localparam int GW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        en_i = 1'b0;
  logic [63:0] txd;
  logic [7:0]  txc;

  int    n_chk = 0;
  int    n_err = 0;
  int    pkt_n = 0;
  bit    chk_on = 1'b0;
  bit    mdl_on = 1'b0;
  bit    done = 1'b0;
  string scen = "R1";

  logic [63:0] qd[$];
  logic [7:0]  qc[$];
  string       qt[$];

  logic [63:0] exp_d = {8{8'h07}};
  logic [7:0]  exp_c = 8'hFF;
  string       exp_t = "R1";

  always #4 clk = ~clk;

  xgmii_frame_gen #(.PAYLOAD_WORDS(PW), .GAP_WORDS(GW)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (en_i),
    .txd    (txd),
    .txc    (txc)
  );

  task automatic push_frame();
    logic [63:0] w;
    qd.push_back({8'hD5, {6{8'h55}}, 8'hFB}); qc.push_back(8'h01); qt.push_back("R4");
    for (int wi = 0; wi < PW; wi++) begin
      for (int k = 0; k < 8; k++) w[k*8 +: 8] = 8'((8*wi + k) % 256);
      qd.push_back(w); qc.push_back(8'h00);
      if (8*wi + 7 >= 256)  qt.push_back("R6");
      else if (pkt_n > 0)   qt.push_back("R7");
      else                  qt.push_back("R5");
    end
    qd.push_back({{7{8'h07}}, 8'hFD}); qc.push_back(8'hFF); qt.push_back("R8");
    for (int g = 0; g < GW; g++) begin
      qd.push_back({8{8'h07}}); qc.push_back(8'hFF); qt.push_back("R9");
    end
    pkt_n++;
  endtask

  // Behavioural reference: expected output after each rising edge
  always @(posedge clk) begin
    if (!rst_n || !mdl_on) begin
      qd.delete(); qc.delete(); qt.delete();
      exp_d = {8{8'h07}}; exp_c = 8'hFF; exp_t = "R1";
    end else begin
      if (qd.size() == 0 && en_i) push_frame();
      if (qd.size() > 0) begin
        exp_d = qd.pop_front(); exp_c = qc.pop_front(); exp_t = qt.pop_front();
      end else begin
        exp_d = {8{8'h07}}; exp_c = 8'hFF; exp_t = "R2";
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_chk++;
      if (txd !== exp_d || txc !== exp_c) begin
        n_err++;
        $display("FAIL %s [%s]: txd=%h txc=%h expected txd=%h txc=%h",
                 exp_t, scen, txd, txc, exp_d, exp_c);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(posedge clk);
    chk_on = 1'b1;
    // R1: idle during and after reset
    cycles(4);
    rst_n = 1'b1;
    cycles(6);
    mdl_on = 1'b1;
    // R2: enable low keeps the line idle
    scen = "R2";
    cycles(5);
    // R3, R9: start on enable and run frames back to back
    scen = "R3";
    en_i = 1'b1;
    cycles(90);
    en_i = 1'b0;
    cycles(50);
    // R10: drop enable in mid-payload
    scen = "R10";
    en_i = 1'b1;
    cycles(12);
    en_i = 1'b0;
    cycles(60);
    // R11: raise enable inside a gap
    scen = "R11";
    en_i = 1'b1;
    cycles(1);
    en_i = 1'b0;
    while (qd.size() != GW) @(negedge clk);
    en_i = 1'b1;
    cycles(20);
    en_i = 1'b0;
    cycles(60);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule